// File: doc/BRIEF.md
# Line K1/K2 Overhead Builder with Remote Defect Override

This block produces the two automatic protection switching bytes (K1 and K2) that a synchronous optical line transmitter places in its line overhead. The protection code comes either from two software-written registers or from bytes captured off a parallel overhead stream that an external serial-to-parallel stage feeds in slot by slot. A control bit selects the source.

The three least significant bits of K2 normally carry part of the protection code. When the line must signal a remote defect, those bits are replaced with the pattern 110. Four triggers can cause this. Loss of signal, loss of frame and line alarm indication are each gated by their own enable. A hardware request arrives as the top bit of the B2 slot on the overhead stream and is honoured only after software enables it. Software can also force the pattern. The override decision is taken once per frame, at the frame strobe, and is held for that whole frame. A trigger that is present at a frame strobe therefore reaches the transmitted K2 within one frame.

Top module: `k2rdi_ctrl`

## Requirements
- R1: Synchronous active-high reset clears every register, so after reset `k1_out` and `k2_out` are 0 and `rdi_active` is 0.
- R2: Register writes use address 0 for control, 1 for the software K1 byte and 2 for the software K2 byte. Address 3 is ignored. Control bit 0 selects the code source: 0 selects the software bytes and 1 selects the captured hardware bytes.
- R3: Slot codes on `oh_slot` are 0 for other, 1 for B2, 2 for K1 and 3 for K2. A K1 or K2 slot with `oh_valid` high updates the hardware byte only when `oh_ins` is 1.
- R4: With no override, `k2_out` equals the selected K2 byte. `k1_out` and `k2_out[7:3]` are never altered by the override logic.
- R5: Control bits 1, 2 and 3 enable the loss-of-signal, loss-of-frame and line-alarm triggers. These match `defect_in` bits 0, 1 and 2. An enabled defect that is present at a frame strobe sets `k2_out[2:0]` to 110. A defect that is not enabled has no effect.
- R6: A B2 slot records bit 7 of `oh_byte` as the hardware request. The request causes an override at the next frame strobe only if control bit 4 is 1.
- R7: `oh_ins` has no effect in a B2 slot. The request bit is recorded whatever its value.
- R8: Control bit 5 forces the override at every frame strobe, whatever the defect state.
- R9: The override state changes only at a frame strobe. Between strobes it holds, even if the defects or the controls change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| oh_valid | input | 1 | Overhead byte present this cycle |
| oh_slot | input | 2 | Slot code of the overhead byte |
| oh_ins | input | 1 | Insert qualifier for K1/K2 slots |
| oh_byte | input | 8 | Overhead data byte |
| defect_in | input | 3 | Defect flags: bit0 LOS, bit1 LOF, bit2 AIS-L |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| k1_out | output | 8 | Transmitted K1 byte |
| k2_out | output | 8 | Transmitted K2 byte |
| rdi_active | output | 1 | Override latched for the current frame |

## Verification
The assertions assume the following about the inputs:
- A frame strobe never falls in the same cycle as a B2 slot.
- At most one overhead byte or one register write changes the output bytes in any cycle.
- Defect flags and controls are taken as sampled at the strobe edge.

The stimulus changes every input on the falling clock edge and issues strobes, slots and writes in separate cycles, so these assumptions always hold. The sweeps cover every pairing of defect enables with defect flags, and every pairing of hardware enable, request bit and insert qualifier.

// File: rtl/k2rdi_pkg.sv
package k2rdi_pkg;

    localparam int BYTE_W  = 8;
    localparam int RDI_W   = 3;
    localparam int NUM_DEF = 3;
    localparam int ADDR_W  = 2;

    localparam logic [RDI_W-1:0]  RDI_CODE  = 3'b110;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_K1   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_K2   = 2'd2;

    typedef enum logic [1:0] {
        SLOT_OTHER = 2'd0,
        SLOT_B2    = 2'd1,
        SLOT_K1    = 2'd2,
        SLOT_K2    = 2'd3
    } oh_slot_e;

    // bit order: [5] force, [4] hw enable, [3:1] defect enables, [0] source
    typedef struct packed {
        logic               force_rdi;
        logic               hw_rdi_en;
        logic [NUM_DEF-1:0] def_en;
        logic               aps_from_hw;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic [BYTE_W-1:0] k1;
        logic [BYTE_W-1:0] k2;
    } aps_t;

    function automatic logic [BYTE_W-1:0] merge_k2(input logic [BYTE_W-1:0] base,
                                                    input logic ovr);
        return ovr ? {base[BYTE_W-1:RDI_W], RDI_CODE} : base;
    endfunction

endpackage

// File: rtl/k2rdi_regs.sv
module k2rdi_regs
    import k2rdi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output ctrl_t             ctrl_q,
    output aps_t              sw_aps_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            sw_aps_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                ADDR_CTRL: ctrl_q      <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
                ADDR_K1:   sw_aps_q.k1 <= reg_wdata;
                ADDR_K2:   sw_aps_q.k2 <= reg_wdata;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/k2rdi_oh_capture.sv
module k2rdi_oh_capture
    import k2rdi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              oh_valid,
    input  oh_slot_e          oh_slot,
    input  logic              oh_ins,
    input  logic [BYTE_W-1:0] oh_byte,
    output aps_t              hw_aps_q,
    output logic              hw_req_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_aps_q <= '0;
            hw_req_q <= 1'b0;
        end else if (oh_valid) begin
            unique case (oh_slot)
                SLOT_B2: hw_req_q <= oh_byte[BYTE_W-1];
                SLOT_K1: if (oh_ins) hw_aps_q.k1 <= oh_byte;
                SLOT_K2: if (oh_ins) hw_aps_q.k2 <= oh_byte;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/k2rdi_decide.sv
module k2rdi_decide
    import k2rdi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  ctrl_t              ctrl,
    input  logic [NUM_DEF-1:0] defect_in,
    input  logic               hw_req,
    output logic               rdi_q
);

    logic [NUM_DEF-1:0] trig;

    for (genvar i = 0; i < NUM_DEF; i++) begin : g_def
        assign trig[i] = ctrl.def_en[i] & defect_in[i];
    end

    logic want;
    assign want = (|trig) | ctrl.force_rdi | (ctrl.hw_rdi_en & hw_req);

    always_ff @(posedge clk) begin
        if (rst)              rdi_q <= 1'b0;
        else if (frame_start) rdi_q <= want;
    end

endmodule

// File: rtl/k2rdi_ctrl.sv
module k2rdi_ctrl
    import k2rdi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              oh_valid,
    input  logic [1:0]        oh_slot,
    input  logic              oh_ins,
    input  logic [7:0]        oh_byte,
    input  logic [2:0]        defect_in,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        k1_out,
    output logic [7:0]        k2_out,
    output logic              rdi_active
);

    ctrl_t ctrl_q;
    aps_t  sw_aps_q;
    aps_t  hw_aps_q;
    aps_t  base;
    logic  hw_req_q;
    logic  rdi_q;

    k2rdi_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .ctrl_q   (ctrl_q),
        .sw_aps_q (sw_aps_q)
    );

    k2rdi_oh_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .oh_valid(oh_valid),
        .oh_slot (oh_slot_e'(oh_slot)),
        .oh_ins  (oh_ins),
        .oh_byte (oh_byte),
        .hw_aps_q(hw_aps_q),
        .hw_req_q(hw_req_q)
    );

    k2rdi_decide u_dec (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .ctrl       (ctrl_q),
        .defect_in  (defect_in),
        .hw_req     (hw_req_q),
        .rdi_q      (rdi_q)
    );

    assign base       = ctrl_q.aps_from_hw ? hw_aps_q : sw_aps_q;
    assign k1_out     = base.k1;
    assign k2_out     = merge_k2(base.k2, rdi_q);
    assign rdi_active = rdi_q;

endmodule

// File: rtl/k2rdi_ctrl_chk.sv
module k2rdi_ctrl_chk
    import k2rdi_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       frame_start,
    input logic       oh_valid,
    input logic       reg_we,
    input logic [2:0] defect_in,
    input ctrl_t      ctrl_q,
    input logic [7:0] k1_out,
    input logic [7:0] k2_out,
    input logic       rdi_active
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (k1_out == 8'h00 && k2_out == 8'h00 && !rdi_active)); // R1

    AST_K1_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        (!reg_we && !oh_valid) |=> $stable(k1_out)); // R4

    AST_DEFECT_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        (frame_start && |(ctrl_q.def_en & defect_in)) |=> (k2_out[2:0] == RDI_CODE)); // R5

    AST_FORCE_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        (frame_start && ctrl_q.force_rdi) |=> (k2_out[2:0] == RDI_CODE && rdi_active)); // R8

    AST_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(rdi_active)); // R9

    AST_K2_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !reg_we && !oh_valid) |=> $stable(k2_out)); // R9

endmodule

bind k2rdi_ctrl k2rdi_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .oh_valid   (oh_valid),
    .reg_we     (reg_we),
    .defect_in  (defect_in),
    .ctrl_q     (ctrl_q),
    .k1_out     (k1_out),
    .k2_out     (k2_out),
    .rdi_active (rdi_active)
);

// File: tb/k2rdi_ctrl_tb.sv
module k2rdi_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic       oh_valid = 1'b0;
    logic [1:0] oh_slot = 2'd0;
    logic       oh_ins = 1'b0;
    logic [7:0] oh_byte = 8'h00;
    logic [2:0] defect_in = 3'b000;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] k1_out;
    logic [7:0] k2_out;
    logic       rdi_active;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    k2rdi_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .oh_valid   (oh_valid),
        .oh_slot    (oh_slot),
        .oh_ins     (oh_ins),
        .oh_byte    (oh_byte),
        .defect_in  (defect_in),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .k1_out     (k1_out),
        .k2_out     (k2_out),
        .rdi_active (rdi_active)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic slot(input logic [1:0] s, input logic [7:0] b, input logic ins);
        oh_valid = 1'b1; oh_slot = s; oh_byte = b; oh_ins = ins;
        @(negedge clk);
        oh_valid = 1'b0; oh_slot = 2'd0; oh_ins = 1'b0;
    endtask

    task automatic frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    function automatic logic [7:0] ovr(input logic [7:0] b, input logic on);
        return on ? {b[7:3], 3'b110} : b;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 k1", k1_out, 8'h00);
        chk("R1 k2", k2_out, 8'h00);
        chk("R1 rdi", {7'd0, rdi_active}, 8'h00);

        wr(2'd1, 8'h3C);
        wr(2'd2, 8'hA5);
        chk("R2 k1 sw", k1_out, 8'h3C);
        chk("R2 k2 sw", k2_out, 8'hA5);
        wr(2'd3, 8'h3F);
        chk("R2 addr3 ignored", {2'b00, 6'h00} | (k2_out ^ 8'hA5), 8'h00);
        frame();
        chk("R2 addr3 no force", k2_out, 8'hA5);

        // R4: low bits pass through with no override
        for (int v = 0; v < 8; v++) begin
            wr(2'd2, {5'b10100, v[2:0]});
            frame();
            chk("R4 k2 pass", k2_out, {5'b10100, v[2:0]});
            chk("R4 k1 pass", k1_out, 8'h3C);
        end
        wr(2'd2, 8'hA5);

        // R5: full sweep of enables vs defects
        for (int e = 0; e < 8; e++) begin
            for (int d = 0; d < 8; d++) begin
                wr(2'd0, {4'b0000, e[2:0], 1'b0});
                defect_in = d[2:0];
                frame();
                chk("R5 k2", k2_out, ovr(8'hA5, (e[2:0] & d[2:0]) != 3'b000));
                chk("R5 k1 R4", k1_out, 8'h3C);
            end
        end
        defect_in = 3'b000;

        // R9: hold within frame
        wr(2'd0, 8'h02);
        frame();
        chk("R9 clean", k2_out, 8'hA5);
        defect_in = 3'b001;
        repeat (5) @(negedge clk);
        chk("R9 hold off", k2_out, 8'hA5);
        frame();
        chk("R9 next frame", k2_out, 8'hA6);
        defect_in = 3'b000;
        wr(2'd0, 8'h00);
        repeat (5) @(negedge clk);
        chk("R9 hold on", k2_out, 8'hA6);
        chk("R9 rdi held", {7'd0, rdi_active}, 8'h01);
        frame();
        chk("R9 cleared", k2_out, 8'hA5);

        // R6/R7: hw enable x request x insert qualifier
        for (int c = 0; c < 8; c++) begin
            wr(2'd0, {3'b000, c[2], 4'b0000});
            slot(2'd1, {c[1], 7'h15}, c[0]);
            frame();
            chk("R6 R7 k2", k2_out, ovr(8'hA5, c[2] & c[1]));
        end
        wr(2'd0, 8'h00);

        // R8: force
        wr(2'd0, 8'h20);
        frame();
        chk("R8 force k2", k2_out, 8'hA6);
        chk("R8 force k1", k1_out, 8'h3C);
        wr(2'd0, 8'h00);
        frame();
        chk("R8 release", k2_out, 8'hA5);

        // R2/R3: hardware source capture
        wr(2'd0, 8'h01);
        slot(2'd2, 8'h5A, 1'b1);
        slot(2'd3, 8'hC3, 1'b1);
        chk("R3 hw k1", k1_out, 8'h5A);
        chk("R3 hw k2", k2_out, 8'hC3);
        slot(2'd2, 8'hFF, 1'b0);
        slot(2'd3, 8'h00, 1'b0);
        chk("R3 k1 ins0", k1_out, 8'h5A);
        chk("R3 k2 ins0", k2_out, 8'hC3);
        slot(2'd0, 8'h99, 1'b1);
        chk("R3 other slot", k1_out, 8'h5A);
        wr(2'd0, 8'h21);
        frame();
        chk("R8 hw k2", k2_out, 8'hC6);
        chk("R4 hw k1", k1_out, 8'h5A);
        wr(2'd0, 8'h00);
        chk("R2 back sw", k1_out, 8'h3C);

        // R1: reset clears again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 k1 again", k1_out, 8'h00);
        chk("R1 k2 again", k2_out, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule